// File: doc/BRIEF.md
# Load-Use Interlock for a Five-Stage Pipeline

This block sits in the decode stage of an in-order five-stage pipeline. It owns the program counter, the fetch/decode pipeline register and the control half of the decode/execute register. Each cycle it compares the source register numbers of the instruction being decoded with the destination of a load that has just entered execute. If the loaded value cannot yet be forwarded, it holds the front of the pipeline for one cycle and sends an all-zero control word into execute. Forwarding and branch redirection live elsewhere.

The stall decision is combinational within the cycle. While it is high, the program counter and the fetch/decode register keep their contents, so the same instruction is decoded again and the same following instruction is fetched again. At the next edge the decode/execute control word is cleared, which turns that slot into a no-operation. One bubble is always enough: by the time the dependent instruction reaches execute, the load result is in the memory/writeback register and can be forwarded.

A two-state sequencer tracks whether execute holds a real instruction or an inserted bubble. In state FLOW execute holds a real instruction or the reset value. In state HOLD execute holds a bubble. The transitions are:
- FLOW to HOLD, named `stall_seen`, when the stall is raised.
- HOLD to FLOW, named `bubble_done`, unconditionally on the next cycle.
- FLOW to FLOW, named `no_hazard`, otherwise.

Top module: `lduse_interlock`

## Requirements
- R1: While reset is held, and right after it, the program counter is 0, the fetch/decode word is 0, the decode/execute control word is all zero, the stall output is low and the sequencer is in FLOW (`bubble_in_ex` low).
- R2: The stall output `ctrl_zero` rises in the same cycle when the decode/execute control has its memory-read bit set and its Rt number equals the Rs field (bits 25:21) or the Rt field (bits 20:16) of the fetch/decode word.
- R3: A load whose Rt number is 0 never raises the stall, even when register 0 is named as a source.
- R4: `pc_write` and `ifid_write` are each the inverse of `ctrl_zero`. During a stalled cycle, the program counter and the fetch/decode word keep their values across the next edge.
- R5: The edge that ends a stalled cycle writes an all-zero control word into decode/execute.
- R6: Each hazard inserts exactly one bubble. The cycle after a stall is never stalled, and `bubble_in_ex` is high in that cycle only. At the following edge the dependent instruction enters decode/execute.
- R7: When decode/execute holds a non-load (a store or an ALU instruction), a register match raises no stall.
- R8: Without a stall, each edge advances the program counter by 4 and loads the fetched word into fetch/decode. It also loads decode/execute with the control decoded from the opcode (bits 31:26). The control word packs these bits from bit 8 down to bit 0: reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, alu_op[1:0]. The decoded values are:
  - opcode 0 (R-type) gives 0x122;
  - opcode 35 (load) gives 0x0F0;
  - opcode 43 (store) gives 0x088;
  - opcode 4 (branch-equal) gives 0x005;
  - any other opcode gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_word | input | 32 | Instruction word read at `pc_q` |
| pc_q | output | 32 | Program counter |
| pc_write | output | 1 | Program counter update enable |
| ifid_write | output | 1 | Fetch/decode register update enable |
| ctrl_zero | output | 1 | Stall: clear decode/execute control at the next edge |
| ifid_word | output | 32 | Instruction held in fetch/decode |
| idex_ctrl | output | 9 | Control word held in decode/execute |
| idex_rs | output | 5 | Rs number held in decode/execute |
| idex_rt | output | 5 | Rt number held in decode/execute |
| bubble_in_ex | output | 1 | Sequencer in HOLD: execute holds an inserted bubble |

## Verification
Every cycle, the assertions check these properties:
- a stall freezes the program counter and fetch/decode;
- a stall is followed by a zero control word;
- a HOLD cycle never stalls again;
- a load with Rt 0, or any non-load, never stalls;
- an unstalled cycle advances the program counter by 4.

Some behaviour depends on a whole instruction stream and only the bench's program can show it. This covers the same-cycle rise of the stall for an Rs use and for an Rt use, and back-to-back dependent loads costing one bubble each. It also covers an independent load, or a load followed by an unrelated instruction, costing nothing, and the re-decoded instruction reaching execute with its proper control word after the bubble.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

    // Instruction field layout
    localparam int OPC_HI = 31;
    localparam int OPC_LO = 26;
    localparam int RS_HI  = 25;
    localparam int RS_LO  = 21;
    localparam int RT_HI  = 20;
    localparam int RT_LO  = 16;

    // Opcodes
    localparam logic [5:0] OPC_ALU   = 6'd0;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;
    localparam logic [5:0] OPC_BEQ   = 6'd4;

    // Control word carried into execute, MSB first
    typedef struct packed {
        logic       reg_dst;
        logic       alu_src;
        logic       mem_to_reg;
        logic       reg_write;
        logic       mem_read;
        logic       mem_write;
        logic       branch;
        logic [1:0] alu_op;
    } ex_ctrl_t;

    localparam int CTRL_W = $bits(ex_ctrl_t);

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } ilk_state_t;

endpackage

// File: rtl/ldu_decode.sv
module ldu_decode
    import ldu_pkg::*;
(
    input  logic [5:0] opcode,
    output ex_ctrl_t   ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (opcode)
            OPC_ALU: begin
                ctrl.reg_dst   = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.alu_op    = 2'b10;
            end
            OPC_LOAD: begin
                ctrl.alu_src    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_write  = 1'b1;
                ctrl.mem_read   = 1'b1;
            end
            OPC_STORE: begin
                ctrl.alu_src   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = 2'b01;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/ldu_detect.sv
module ldu_detect #(
    parameter int REG_AW = 5
) (
    input  logic              ex_mem_read,
    input  logic [REG_AW-1:0] ex_rt,
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    output logic              stall
);

    logic ex_rt_live;
    logic src_match;

    always_comb begin
        ex_rt_live = (ex_rt != '0);
        src_match  = (ex_rt == id_rs) || (ex_rt == id_rt);
        stall      = ex_mem_read && ex_rt_live && src_match;
    end

endmodule

// File: rtl/ldu_fsm.sv
module ldu_fsm
    import ldu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    output logic in_hold
);

    ilk_state_t state_q;
    ilk_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLOW;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_FLOW: state_d = stall ? ST_HOLD : ST_FLOW;  // stall_seen / no_hazard
            ST_HOLD: state_d = ST_FLOW;                    // bubble_done
            default: state_d = ST_FLOW;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_FLOW: in_hold = 1'b0;
            ST_HOLD: in_hold = 1'b1;
            default: in_hold = 1'b0;
        endcase
    end

    // R6: the bubble slot can never request a second stall
    a_r6_single_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !stall);

endmodule

// File: rtl/ldu_front.sv
module ldu_front #(
    parameter int PC_W    = 32,
    parameter int INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    input  logic [INSTR_W-1:0] fetch_word,
    output logic [PC_W-1:0]    pc_q,
    output logic [INSTR_W-1:0] ifid_q
);

    localparam int STEP = INSTR_W / 8;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            ifid_q <= '0;
        end else if (advance) begin
            pc_q   <= pc_q + PC_W'(STEP);
            ifid_q <= fetch_word;
        end
    end

endmodule

// File: rtl/lduse_interlock.sv
module lduse_interlock
    import ldu_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int INSTR_W  = 32,
    parameter int NUM_REGS = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [INSTR_W-1:0]          fetch_word,
    output logic [PC_W-1:0]             pc_q,
    output logic                        pc_write,
    output logic                        ifid_write,
    output logic                        ctrl_zero,
    output logic [INSTR_W-1:0]          ifid_word,
    output logic [CTRL_W-1:0]           idex_ctrl,
    output logic [$clog2(NUM_REGS)-1:0] idex_rs,
    output logic [$clog2(NUM_REGS)-1:0] idex_rt,
    output logic                        bubble_in_ex
);

    localparam int REG_AW = $clog2(NUM_REGS);
    localparam int STEP   = INSTR_W / 8;

    logic              stall;
    logic [REG_AW-1:0] id_rs;
    logic [REG_AW-1:0] id_rt;
    ex_ctrl_t          dec_ctrl;
    ex_ctrl_t          ex_ctrl_q;

    assign id_rs = ifid_word[RS_HI:RS_LO];
    assign id_rt = ifid_word[RT_HI:RT_LO];

    ldu_front #(.PC_W(PC_W), .INSTR_W(INSTR_W)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (!stall),
        .fetch_word (fetch_word),
        .pc_q       (pc_q),
        .ifid_q     (ifid_word)
    );

    ldu_decode u_dec (
        .opcode (ifid_word[OPC_HI:OPC_LO]),
        .ctrl   (dec_ctrl)
    );

    ldu_detect #(.REG_AW(REG_AW)) u_det (
        .ex_mem_read (ex_ctrl_q.mem_read),
        .ex_rt       (idex_rt),
        .id_rs       (id_rs),
        .id_rt       (id_rt),
        .stall       (stall)
    );

    ldu_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (stall),
        .in_hold (bubble_in_ex)
    );

    // Decode/execute register: control cleared on a stall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_ctrl_q <= '0;
            idex_rs   <= '0;
            idex_rt   <= '0;
        end else begin
            ex_ctrl_q <= stall ? ex_ctrl_t'('0) : dec_ctrl;
            idex_rs   <= id_rs;
            idex_rt   <= id_rt;
        end
    end

    assign idex_ctrl  = ex_ctrl_q;
    assign ctrl_zero  = stall;
    assign pc_write   = !stall;
    assign ifid_write = !stall;

    // R4: a stalled cycle leaves PC and fetch/decode unchanged
    a_r4_front_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (pc_q == $past(pc_q)) && (ifid_word == $past(ifid_word)));

    // R5: a stall is followed by an all-zero control word
    a_r5_zero_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (idex_ctrl == '0));

    // R3: a load targeting register 0 never stalls
    a_r3_rt_zero_free: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_rt == '0) |-> !ctrl_zero);

    // R7: a non-load in execute never stalls
    a_r7_nonload_free: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_ctrl_q.mem_read |-> !ctrl_zero);

    // R8: unstalled cycles step the PC by one instruction
    a_r8_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (pc_q == $past(pc_q) + PC_W'(STEP)));

endmodule

// File: tb/lduse_interlock_test.sv
module lduse_interlock_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_word;
    logic [31:0] pc_q;
    logic        pc_write, ifid_write, ctrl_zero, bubble_in_ex;
    logic [31:0] ifid_word;
    logic [8:0]  idex_ctrl;
    logic [4:0]  idex_rs, idex_rt;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2ns clk = ~clk;

    lduse_interlock uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_word   (fetch_word),
        .pc_q         (pc_q),
        .pc_write     (pc_write),
        .ifid_write   (ifid_write),
        .ctrl_zero    (ctrl_zero),
        .ifid_word    (ifid_word),
        .idex_ctrl    (idex_ctrl),
        .idex_rs      (idex_rs),
        .idex_rt      (idex_rt),
        .bubble_in_ex (bubble_in_ex)
    );

    function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] rtype(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    // Program: load 35, store 43, R-type 0 (add 32, sub 34)
    function automatic logic [31:0] prog_word(input logic [5:0] idx);
        case (idx)
            6'd0:  return itype(6'd35, 5'd1, 5'd5, 16'd0);    // load r5
            6'd1:  return rtype(5'd5, 5'd2, 5'd6, 6'd32);     // add uses r5 as Rs
            6'd2:  return itype(6'd35, 5'd1, 5'd7, 16'd4);    // load r7
            6'd3:  return itype(6'd35, 5'd7, 5'd8, 16'd8);    // load addr from r7
            6'd4:  return itype(6'd35, 5'd1, 5'd9, 16'd0);    // independent load
            6'd5:  return rtype(5'd3, 5'd4, 5'd10, 6'd34);    // unrelated sub
            6'd6:  return itype(6'd35, 5'd1, 5'd11, 16'd0);   // load r11
            6'd7:  return itype(6'd43, 5'd2, 5'd11, 16'd0);   // store uses r11 as Rt
            6'd8:  return itype(6'd35, 5'd1, 5'd0, 16'd0);    // load to r0
            6'd9:  return rtype(5'd0, 5'd0, 5'd12, 6'd32);    // reads r0
            6'd10: return itype(6'd43, 5'd1, 5'd13, 16'd0);   // store r13
            6'd11: return rtype(5'd13, 5'd13, 5'd14, 6'd32);  // reads r13
            default: return 32'd0;
        endcase
    endfunction

    always_comb fetch_word = prog_word(pc_q[7:2]);

    // Per edge after reset: {pc[7:0], stall, bubble, ctrl[8:0]}
    localparam int N_ROWS = 16;
    localparam logic [18:0] ROWS [N_ROWS] = '{
        {8'd4,  1'b0, 1'b0, 9'h122},  // e1  nop in EX
        {8'd8,  1'b1, 1'b0, 9'h0F0},  // e2  load r5 vs Rs use   (R2)
        {8'd8,  1'b0, 1'b1, 9'h000},  // e3  bubble              (R5 R6)
        {8'd12, 1'b0, 1'b0, 9'h122},  // e4  add re-decoded      (R6)
        {8'd16, 1'b1, 1'b0, 9'h0F0},  // e5  load-load dependent (R2)
        {8'd16, 1'b0, 1'b1, 9'h000},  // e6  bubble
        {8'd20, 1'b0, 1'b0, 9'h0F0},  // e7  dependent load in EX
        {8'd24, 1'b0, 1'b0, 9'h0F0},  // e8  independent load
        {8'd28, 1'b0, 1'b0, 9'h122},  // e9  sub in EX
        {8'd32, 1'b1, 1'b0, 9'h0F0},  // e10 load r11 vs Rt use  (R2)
        {8'd32, 1'b0, 1'b1, 9'h000},  // e11 bubble
        {8'd36, 1'b0, 1'b0, 9'h088},  // e12 store in EX
        {8'd40, 1'b0, 1'b0, 9'h0F0},  // e13 load r0, no stall   (R3)
        {8'd44, 1'b0, 1'b0, 9'h122},  // e14
        {8'd48, 1'b0, 1'b0, 9'h088},  // e15 store r13 in EX     (R7)
        {8'd52, 1'b0, 1'b0, 9'h122}   // e16
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #20us;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: state while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pc", pc_q, 32'd0);
        check("R1 ctrl", 32'(idex_ctrl), 32'd0);
        check("R1 stall", 32'(ctrl_zero), 32'd0);
        check("R1 bubble", 32'(bubble_in_ex), 32'd0);
        check("R1 ifid", ifid_word, 32'd0);
        rst_n = 1'b1;

        for (int e = 0; e < N_ROWS; e++) begin
            @(posedge clk);
            @(negedge clk);
            check("R8 pc", pc_q, 32'(ROWS[e][18:11]));
            check("R2 stall", 32'(ctrl_zero), 32'(ROWS[e][10]));
            check("R6 bubble", 32'(bubble_in_ex), 32'(ROWS[e][9]));
            check("R5 ctrl", 32'(idex_ctrl), 32'(ROWS[e][8:0]));
            check("R4 pc_write", 32'(pc_write), 32'(!ROWS[e][10]));
            check("R4 ifid_write", 32'(ifid_write), 32'(!ROWS[e][10]));
            if (e == 2) begin
                // R4: dependent instruction still held in fetch/decode
                check("R4 ifid hold", ifid_word, prog_word(6'd1));
            end
            if (e == 3) begin
                // R6: the re-decoded add carries its own source numbers
                check("R6 idex_rs", 32'(idex_rs), 32'd5);
            end
            if (e == 12) begin
                // R3: load with Rt 0 sits in execute, r0 reader not stalled
                check("R3 idex_rt", 32'(idex_rt), 32'd0);
            end
        end

        // R1: reset in mid-run returns to the reset state
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid pc", pc_q, 32'd0);
        check("R1 mid ctrl", 32'(idex_ctrl), 32'd0);
        check("R1 mid stall", 32'(ctrl_zero), 32'd0);
        check("R1 mid bubble", 32'(bubble_in_ex), 32'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule